// File: doc/BRIEF.md
# ADC Sequence Run Controller

This block owns the software-visible run bit of a multi-slot ADC sequencer and the state machine that walks the slots. Software writes a 1 to launch a pass over slots 0 through a programmable last slot, and writes a 0 to halt it. In one-pass mode the run bit drops by itself once the last slot has converted. In repeating mode the slot index wraps back to 0 and the pass restarts until software halts it. The run bit reads back as `busy`.

Each slot may be preceded by an extended acquisition wait of a programmable number of cycles, during which `acq_wait` is high. The slot's conversion is then requested from the datapath by holding `conv_req` high until the datapath answers with `conv_done`. A halt written during an acquisition wait ends the wait at once. A halt written during a conversion lets that conversion finish first. A one-cycle `start_pulse` marks every accepted launch so that a flag unit can act on it.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset `busy`, `start_pulse`, `conv_req` and `acq_wait` are 0 and `slot_idx` is 0.
- R2: A write of 1 (`ctl_wr`=1, `ctl_wdata`=1) while `busy` is 0 sets `busy` one cycle later, and `start_pulse` is high for exactly that one cycle.
- R3: One pass converts slots 0 up to the effective last slot in ascending order, with one `conv_req` per slot, and `conv_req` stays high until `conv_done` is seen.
- R4: When `acq_len` is N>0, `acq_wait` is high for exactly N cycles before each conversion request. When `acq_len` is 0, `acq_wait` never rises.
- R5: In one-pass mode (`cont_mode`=0), `busy` returns to 0 after the last slot's conversion and no further request follows.
- R6: In repeating mode (`cont_mode`=1), the slot after the last slot is slot 0 and `busy` stays 1.
- R7: A write of 0 during a conversion keeps `conv_req` high until `conv_done`. The controller then goes idle with no further conversion.
- R8: A write of 0 during an acquisition wait drops `acq_wait` and `busy` two clock edges after the write, with no conversion of that slot.
- R9: A write of 1 while a halt is pending is ignored. `busy` ends at 0 and no `start_pulse` occurs.
- R10: A write of 1 while `busy` is 1 and no halt is pending has no effect: no `start_pulse`, and the pass runs unchanged.
- R11: A `last_slot` value above SLOTS-1 is treated as SLOTS-1, and `slot_idx` never exceeds SLOTS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Software write strobe for the run bit |
| ctl_wdata | input | 1 | Value written to the run bit |
| cont_mode | input | 1 | 1 = repeating passes, 0 = single pass |
| last_slot | input | SLOT_W | Index of the final slot of a pass |
| acq_len | input | ACQ_W | Extended acquisition cycles per slot, 0 = none |
| conv_done | input | 1 | Datapath reports the requested conversion finished |
| busy | output | 1 | Run bit read-back |
| start_pulse | output | 1 | One-cycle mark of an accepted launch |
| conv_req | output | 1 | Conversion request to the datapath, held until done |
| acq_wait | output | 1 | Extended acquisition wait in progress |
| slot_idx | output | SLOT_W | Slot currently being handled |

## Verification
Sequences are run with no acquisition wait and with a short one, over a short and a full-length slot range, and in both pass modes. This shows that slot order, wait length and wrap behaviour depend on the inputs that should control them. Halts are written in the two phases where they act differently: during a stalled conversion and during a long acquisition wait. This separates the deferred stop from the immediate one. Extra launch writes are issued while a halt is pending and while the controller is running normally. This shows that neither one creates a launch or disturbs the pass. An oversized last-slot value shows the clamp.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_NEXT = 2'd3
  } seq_state_e;

  // Effective last slot: requests beyond the table are pinned to its end.
  function automatic int unsigned clamp_slot(int unsigned req, int unsigned slots);
    return (req >= slots) ? (slots - 1) : req;
  endfunction

  // Slot following cur; wraps to 0 after the last slot.
  function automatic int unsigned advance_slot(int unsigned cur, int unsigned last);
    return (cur >= last) ? 0 : (cur + 1);
  endfunction

  // Entry phase of a slot: wait first only when a wait length is programmed.
  function automatic seq_state_e entry_state(logic wait_needed);
    return wait_needed ? ST_ACQ : ST_CONV;
  endfunction

endpackage

// File: rtl/adc_seq_runbit.sv
module adc_seq_runbit (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wdata,
  input  logic halt,
  output logic run_q,
  output logic stop_q,
  output logic launch_q
);

  logic accept_start;
  logic accept_stop;

  assign accept_start = wr && wdata && !run_q && !halt;
  assign accept_stop  = wr && !wdata && run_q && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      stop_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      launch_q <= accept_start;
      if (halt) begin
        run_q  <= 1'b0;
        stop_q <= 1'b0;
      end else begin
        if (accept_start) run_q  <= 1'b1;
        if (accept_stop)  stop_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/adc_seq_acqtimer.sv
module adc_seq_acqtimer #(
  parameter int ACQ_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ACQ_W-1:0] load_val,
  input  logic             active,
  output logic             expire
);

  localparam logic [ACQ_W-1:0] ONE = ACQ_W'(1);

  logic [ACQ_W-1:0] cnt_q;

  assign expire = active && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (active && (cnt_q != '0)) begin
      cnt_q <= cnt_q - ONE;
    end
  end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 24,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              stop_req,
  input  logic              cont_mode,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic              wait_needed,
  input  logic              acq_expire,
  input  logic              conv_done,
  output seq_state_e        state_q,
  output logic [SLOT_W-1:0] slot_q,
  output logic              timer_load,
  output logic              halt
);

  seq_state_e        state_d;
  logic [SLOT_W-1:0] slot_d;
  logic [SLOT_W-1:0] last_eff;
  logic [SLOT_W-1:0] slot_after;
  logic              at_last;

  assign last_eff   = SLOT_W'(clamp_slot(32'(last_slot), SLOTS));
  assign slot_after = SLOT_W'(advance_slot(32'(slot_q), 32'(last_eff)));
  assign at_last    = (slot_q >= last_eff);

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    halt    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (stop_req) begin
          halt = 1'b1;
        end else if (run) begin
          slot_d  = '0;
          state_d = entry_state(wait_needed);
        end
      end
      ST_ACQ: begin
        if (stop_req) begin
          halt    = 1'b1;
          state_d = ST_IDLE;
        end else if (acq_expire) begin
          state_d = ST_CONV;
        end
      end
      ST_CONV: begin
        if (conv_done) begin
          if (stop_req) begin
            halt    = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_NEXT;
          end
        end
      end
      ST_NEXT: begin
        if (stop_req || (at_last && !cont_mode)) begin
          halt    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          slot_d  = slot_after;
          state_d = entry_state(wait_needed);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign timer_load = (state_d == ST_ACQ) && (state_q != ST_ACQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end else begin
      state_q <= state_d;
      slot_q  <= slot_d;
    end
  end

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SLOTS  = 24,
  parameter int ACQ_W  = 8,
  parameter int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  input  logic              cont_mode,
  input  logic [SLOT_W-1:0] last_slot,
  input  logic [ACQ_W-1:0]  acq_len,
  input  logic              conv_done,
  output logic              busy,
  output logic              start_pulse,
  output logic              conv_req,
  output logic              acq_wait,
  output logic [SLOT_W-1:0] slot_idx
);

  // Named internal events, visible to the bound checker.
  logic              run_bit;
  logic              stop_pending;
  logic              fsm_halt;
  logic              timer_load;
  logic              acq_expire;
  logic              wait_needed;
  seq_state_e        state;
  logic [SLOT_W-1:0] slot;

  assign wait_needed = (acq_len != '0);

  adc_seq_runbit u_runbit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (ctl_wr),
    .wdata    (ctl_wdata),
    .halt     (fsm_halt),
    .run_q    (run_bit),
    .stop_q   (stop_pending),
    .launch_q (start_pulse)
  );

  adc_seq_acqtimer #(.ACQ_W(ACQ_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (acq_len),
    .active   (state == ST_ACQ),
    .expire   (acq_expire)
  );

  adc_seq_fsm #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run_bit),
    .stop_req    (stop_pending),
    .cont_mode   (cont_mode),
    .last_slot   (last_slot),
    .wait_needed (wait_needed),
    .acq_expire  (acq_expire),
    .conv_done   (conv_done),
    .state_q     (state),
    .slot_q      (slot),
    .timer_load  (timer_load),
    .halt        (fsm_halt)
  );

  assign busy     = run_bit;
  assign conv_req = (state == ST_CONV);
  assign acq_wait = (state == ST_ACQ);
  assign slot_idx = slot;

endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int SLOTS  = 24,
  parameter int SLOT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              start_pulse,
  input logic              conv_req,
  input logic              conv_done,
  input logic              acq_wait,
  input logic              stop_pending,
  input logic [SLOT_W-1:0] slot_idx
);

  localparam logic [SLOT_W-1:0] TOP = SLOT_W'(SLOTS - 1);

  a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);

  a_r2_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req && !conv_done) |=> conv_req);

  a_r4_wait_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(acq_wait && conv_req));

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!conv_req && !acq_wait));

  a_r7_stop_defer: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pending && conv_req && !conv_done) |=> conv_req);

  a_r8_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_pending && acq_wait) |=> (!acq_wait && !busy));

  a_r9_no_launch: assert property (@(posedge clk) disable iff (!rst_n)
    stop_pending |=> !start_pulse);

  a_r11_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx <= TOP);

endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .start_pulse  (start_pulse),
  .conv_req     (conv_req),
  .conv_done    (conv_done),
  .acq_wait     (acq_wait),
  .stop_pending (stop_pending),
  .slot_idx     (slot_idx)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

  localparam int SLOTS  = 24;
  localparam int ACQ_W  = 8;
  localparam int SLOT_W = $clog2(SLOTS);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              ctl_wr = 1'b0;
  logic              ctl_wdata = 1'b0;
  logic              cont_mode = 1'b0;
  logic [SLOT_W-1:0] last_slot = '0;
  logic [ACQ_W-1:0]  acq_len = '0;
  logic              conv_done;
  logic              busy, start_pulse, conv_req, acq_wait;
  logic [SLOT_W-1:0] slot_idx;

  int checks = 0;
  int fails = 0;
  int nconv = 0;
  int pulses = 0;
  int acq_run = 0;
  bit stall = 1'b0;
  int slot_log [64];
  int acq_log [64];

  always #2.5 clk = ~clk;

  adc_seq_ctrl #(.SLOTS(SLOTS), .ACQ_W(ACQ_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .cont_mode(cont_mode), .last_slot(last_slot), .acq_len(acq_len),
    .conv_done(conv_done), .busy(busy), .start_pulse(start_pulse),
    .conv_req(conv_req), .acq_wait(acq_wait), .slot_idx(slot_idx)
  );

  // Datapath model: answers each request after two cycles unless stalled.
  initial begin
    int lat;
    lat = 0;
    conv_done = 1'b0;
    forever begin
      @(negedge clk);
      if (start_pulse) pulses++;
      if (acq_wait) acq_run++;
      if (conv_done) begin
        conv_done = 1'b0;
      end else if (conv_req && !stall) begin
        if (lat >= 1) begin
          conv_done = 1'b1;
          lat = 0;
          if (nconv < 64) begin
            slot_log[nconv] = int'(slot_idx);
            acq_log[nconv]  = acq_run;
          end
          nconv++;
          acq_run = 0;
        end else begin
          lat++;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_bit(bit v);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic clear_log();
    @(negedge clk);
    nconv = 0;
    acq_run = 0;
  endtask

  task automatic t_reset();
    check(!busy && !start_pulse && !conv_req && !acq_wait && slot_idx == 0,
          "R1", {busy, start_pulse, conv_req, acq_wait}, 0, "reset outputs");
  endtask

  task automatic t_launch();
    int p0;
    cont_mode = 1'b0; last_slot = 0; acq_len = 0;
    clear_log();
    p0 = pulses;
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
    check(busy && start_pulse, "R2", {busy, start_pulse}, 3, "busy and pulse after launch");
    @(negedge clk);
    check(!start_pulse, "R2", start_pulse, 0, "pulse width one cycle");
    wait_idle();
    check(pulses - p0 == 1, "R2", pulses - p0, 1, "launch pulse count");
  endtask

  task automatic t_single();
    bit ok;
    cont_mode = 1'b0; last_slot = 3; acq_len = 0;
    clear_log();
    write_bit(1'b1);
    wait_idle();
    repeat (10) @(negedge clk);
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (slot_log[i] != i) ok = 1'b0;
    check(ok, "R3", slot_log[3], 3, "ascending slot order");
    check(nconv == 4, "R5", nconv, 4, "conversions in one pass");
    check(!busy && !conv_req, "R5", busy, 0, "idle after pass");
    ok = 1'b1;
    for (int i = 0; i < 4; i++) if (acq_log[i] != 0) ok = 1'b0;
    check(ok, "R4", acq_log[0], 0, "no wait with zero length");
  endtask

  task automatic t_acq();
    bit ok;
    cont_mode = 1'b0; last_slot = 1; acq_len = 3;
    clear_log();
    write_bit(1'b1);
    wait_idle();
    ok = (nconv == 2);
    for (int i = 0; i < 2; i++) if (acq_log[i] != 3) ok = 1'b0;
    check(ok, "R4", acq_log[1], 3, "wait cycles per slot");
  endtask

  task automatic t_cont();
    bit ok;
    cont_mode = 1'b1; last_slot = 2; acq_len = 0;
    clear_log();
    write_bit(1'b1);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (nconv >= 7) break;
    end
    check(busy, "R6", busy, 1, "busy during repeat");
    write_bit(1'b0);
    wait_idle();
    ok = (nconv >= 7);
    for (int i = 0; i < 7; i++) if (slot_log[i] != i % 3) ok = 1'b0;
    check(ok, "R6", slot_log[3], 0, "wrap to slot 0");
    check(!busy, "R6", busy, 0, "halt ends repeating mode");
    cont_mode = 1'b0;
  endtask

  task automatic t_stop_conv();
    int n0;
    cont_mode = 1'b0; last_slot = 10; acq_len = 0;
    clear_log();
    stall = 1'b1;
    write_bit(1'b1);
    repeat (3) @(negedge clk);
    n0 = nconv;
    write_bit(1'b0);
    repeat (5) @(negedge clk);
    check(conv_req && busy, "R7", conv_req, 1, "request held after halt");
    stall = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    check(nconv == n0 + 1, "R7", nconv, n0 + 1, "only current conversion finishes");
  endtask

  task automatic t_stop_acq();
    cont_mode = 1'b0; last_slot = 5; acq_len = 50;
    clear_log();
    write_bit(1'b1);
    repeat (5) @(negedge clk);
    check(acq_wait, "R8", acq_wait, 1, "in acquisition wait");
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = 1'b0;
    @(negedge clk);
    ctl_wr = 1'b0;
    check(acq_wait, "R8", acq_wait, 1, "wait one edge after halt");
    @(negedge clk);
    check(!acq_wait && !busy, "R8", {acq_wait, busy}, 0, "wait ended at once");
    repeat (10) @(negedge clk);
    check(nconv == 0 && !conv_req, "R8", nconv, 0, "no conversion of cut slot");
  endtask

  task automatic t_start_pending();
    int p0;
    cont_mode = 1'b0; last_slot = 10; acq_len = 0;
    clear_log();
    stall = 1'b1;
    write_bit(1'b1);
    repeat (3) @(negedge clk);
    p0 = pulses;
    write_bit(1'b0);
    write_bit(1'b1);
    repeat (3) @(negedge clk);
    stall = 1'b0;
    wait_idle();
    repeat (10) @(negedge clk);
    check(!busy, "R9", busy, 0, "start while halting ignored");
    check(pulses == p0, "R9", pulses - p0, 0, "no launch pulse");
  endtask

  task automatic t_restart_running();
    int p0;
    cont_mode = 1'b0; last_slot = 4; acq_len = 2;
    clear_log();
    write_bit(1'b1);
    p0 = pulses;
    repeat (4) @(negedge clk);
    write_bit(1'b1);
    wait_idle();
    check(pulses == p0, "R10", pulses - p0, 0, "no pulse on extra start");
    check(nconv == 5 && slot_log[4] == 4, "R10", nconv, 5, "pass unchanged");
  endtask

  task automatic t_clamp();
    cont_mode = 1'b0; last_slot = '1; acq_len = 0;
    clear_log();
    write_bit(1'b1);
    wait_idle();
    check(nconv == SLOTS, "R11", nconv, SLOTS, "conversions with oversized last slot");
    check(slot_log[SLOTS-1] == SLOTS - 1, "R11", slot_log[SLOTS-1], SLOTS - 1, "final slot");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_launch();
    t_single();
    t_acq();
    t_cont();
    t_stop_conv();
    t_stop_acq();
    t_start_pending();
    t_restart_running();
    t_clamp();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule